// File: doc/BRIEF.md
# CAN Fault Confinement Error Tracker

This block keeps the error bookkeeping of a CAN node. It holds an 8-bit receive error count and a 9-bit transmit error count. It moves them according to pulses from the protocol engine, and from those counts it derives three levels: warning, error passive and bus-off. Single-cycle pulses come from the engine for a receive error, a transmit error, a good reception and a good transmission. A 3-bit error-type code goes with each error pulse. The block records that code as the last error code. A good transfer clears the code. A small software write port can force the code to the reserved value 111 to mark that software has seen it.

A fault state machine has three states: `FS_ACTIVE` (code 00), `FS_PASSIVE` (01) and `FS_BUSOFF` (10). Its transitions are:
- ACTIVE→PASSIVE when either next count goes above 127.
- PASSIVE→ACTIVE when both next counts are 127 or less.
- ACTIVE→BUSOFF or PASSIVE→BUSOFF when the next transmit count goes above 255.
- BUSOFF→ACTIVE on a recovery request.

While the machine is in BUSOFF, both counters are frozen. The recovery request clears them.

Every output is registered. The effect of an input pulse appears after the next rising clock edge.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset, both counts are 0, the last error code is 000, and the warning, passive and bus-off outputs are 0 with state code 00.
- R2: A receive error pulse raises the receive count by 1, or by 8 when `rx_severe_i` is 1. The count saturates at 255. If a receive error and a good reception arrive in the same cycle, the error takes effect and the good reception is dropped.
- R3: A good reception with no receive error lowers the receive count by 1 and stops at 0. If the count was above 128, it is loaded with 120 instead, so a count of exactly 128 becomes 127.
- R4: A transmit error pulse raises the 9-bit transmit count by 8. A good transmission with no transmit error lowers it by 1 and stops at 0.
- R5: `warn_o` is 1 exactly when either count is 96 or more.
- R6: `passive_o` is 1 exactly when either count is above 127. This includes the bus-off state.
- R7: When the transmit count goes above 255, the block enters bus-off. `busoff_o` then reads 1 and `fault_state_o` reads 10. Outside bus-off, `fault_state_o` reads 01 when passive and 00 otherwise.
- R8: While in bus-off, error and success pulses leave both counts unchanged.
- R9: A recovery request in bus-off clears both counts, `busoff_o` and `passive_o`, and returns the state to 00. Outside bus-off, a recovery request has no effect.
- R10: On any error pulse, the last error code takes the value of `err_code_i`. The codes are: 001 stuff, 010 form, 011 acknowledge, 100 bit-recessive, 101 bit-dominant, 110 CRC.
- R11: A good reception or good transmission in a cycle with no error pulse clears the last error code to 000.
- R12: A software write with data 111 sets the last error code to 111. A write with any other data leaves the code unchanged. A hardware update in the same cycle takes priority over the write.
- R13: `tec_lo_o` shows the low 8 bits of the transmit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_err_i | input | 1 | Receive error pulse |
| rx_severe_i | input | 1 | Selects the step of 8 for a receive error |
| rx_ok_i | input | 1 | Good reception pulse |
| tx_err_i | input | 1 | Transmit error pulse |
| tx_ok_i | input | 1 | Good transmission pulse |
| err_code_i | input | 3 | Error type that goes with an error pulse |
| recover_i | input | 1 | Recovery request that leaves bus-off |
| sw_wr_i | input | 1 | Software write strobe for the last error code |
| sw_lec_i | input | 3 | Software write data |
| rec_o | output | 8 | Receive error count |
| tec_lo_o | output | 8 | Low byte of the transmit error count |
| lec_o | output | 3 | Last error code |
| warn_o | output | 1 | Warning level reached |
| passive_o | output | 1 | Error passive level reached |
| busoff_o | output | 1 | Bus-off state |
| fault_state_o | output | 2 | Fault state code |

## Verification
The hardest situations to reach from the ports are bus-off and the snap of the receive count from above 128 down to 120. Bus-off needs more than thirty transmit errors with few good transmissions in between. The snap needs a long run of severe receive errors followed by a good reception. The stimulus reaches these in two ways. Directed sequences drive the counts to 128, 129, 255 and 256. The random stimulus runs in phases, and each phase is weighted toward either errors or successes, so it crosses the thresholds, enters bus-off and recovers several times.

// File: rtl/cft_pkg.sv
package cft_pkg;

    typedef enum logic [1:0] {
        FS_ACTIVE  = 2'd0,
        FS_PASSIVE = 2'd1,
        FS_BUSOFF  = 2'd2
    } fault_st_e;

    typedef enum logic [2:0] {
        EC_NONE     = 3'd0,
        EC_STUFF    = 3'd1,
        EC_FORM     = 3'd2,
        EC_ACK      = 3'd3,
        EC_BIT_REC  = 3'd4,
        EC_BIT_DOM  = 3'd5,
        EC_CRC      = 3'd6,
        EC_SOFTWARE = 3'd7
    } err_code_e;

endpackage

// File: rtl/cft_rx_counter.sv
module cft_rx_counter #(
    parameter int CNT_W      = 8,
    parameter int SMALL_STEP = 1,
    parameter int BIG_STEP   = 8,
    parameter int SNAP_ABOVE = 128,
    parameter int SNAP_TO    = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             clear_i,
    input  logic             err_i,
    input  logic             severe_i,
    input  logic             ok_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam int              EXT_W  = CNT_W + 1;
    localparam logic [EXT_W-1:0] STEP_S = EXT_W'(SMALL_STEP);
    localparam logic [EXT_W-1:0] STEP_B = EXT_W'(BIG_STEP);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] SNAP_A  = CNT_W'(SNAP_ABOVE);
    localparam logic [CNT_W-1:0] SNAP_V  = CNT_W'(SNAP_TO);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [EXT_W-1:0] sum;

    always_comb begin
        sum     = {1'b0, cnt_q} + (severe_i ? STEP_B : STEP_S);
        cnt_nxt = cnt_q;
        if (clear_i) begin
            cnt_nxt = '0;
        end else if (!hold_i) begin
            if (err_i) begin
                cnt_nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
            end else if (ok_i) begin
                if (cnt_q > SNAP_A) begin
                    cnt_nxt = SNAP_V;
                end else if (cnt_q != '0) begin
                    cnt_nxt = cnt_q - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/cft_tx_counter.sv
module cft_tx_counter #(
    parameter int TEC_W    = 9,
    parameter int ERR_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             clear_i,
    input  logic             err_i,
    input  logic             ok_i,
    output logic [TEC_W-1:0] cnt_q,
    output logic [TEC_W-1:0] cnt_nxt
);
    localparam int               EXT_W   = TEC_W + 1;
    localparam logic [EXT_W-1:0] STEP_E  = EXT_W'(ERR_STEP);
    localparam logic [TEC_W-1:0] CNT_MAX = '1;
    localparam logic [TEC_W-1:0] ONE     = TEC_W'(1);

    logic [EXT_W-1:0] sum;

    always_comb begin
        sum     = {1'b0, cnt_q} + STEP_E;
        cnt_nxt = cnt_q;
        if (clear_i) begin
            cnt_nxt = '0;
        end else if (!hold_i) begin
            if (err_i) begin
                cnt_nxt = sum[TEC_W] ? CNT_MAX : sum[TEC_W-1:0];
            end else if (ok_i && (cnt_q != '0)) begin
                cnt_nxt = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/cft_lec_reg.sv
module cft_lec_reg #(
    parameter int               LEC_W   = 3,
    parameter logic [LEC_W-1:0] SW_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_any_i,
    input  logic             ok_any_i,
    input  logic [LEC_W-1:0] code_i,
    input  logic             sw_wr_i,
    input  logic [LEC_W-1:0] sw_data_i,
    output logic [LEC_W-1:0] lec_q
);
    logic [LEC_W-1:0] lec_d;

    always_comb begin
        lec_d = lec_q;
        if (err_any_i) begin
            lec_d = code_i;
        end else if (ok_any_i) begin
            lec_d = '0;
        end else if (sw_wr_i && (sw_data_i == SW_CODE)) begin
            lec_d = SW_CODE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lec_q <= '0;
        end else begin
            lec_q <= lec_d;
        end
    end

endmodule

// File: rtl/cft_state_fsm.sv
module cft_state_fsm
    import cft_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int TEC_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 127,
    parameter int OFF_LIM  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recover_i,
    input  logic [CNT_W-1:0] rec_nxt_i,
    input  logic [TEC_W-1:0] tec_nxt_i,
    output fault_st_e        state_o,
    output logic             warn_o,
    output logic             passive_o,
    output logic             busoff_o,
    output logic             clear_o
);
    localparam logic [CNT_W-1:0] R_WARN = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] R_PASS = CNT_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LIM);
    localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] T_OFF  = TEC_W'(OFF_LIM);

    fault_st_e st_q, st_d;
    logic      warn_q;
    logic      warn_hit, pass_hit, off_hit;

    always_comb begin
        warn_hit = (rec_nxt_i >= R_WARN) || (tec_nxt_i >= T_WARN);
        pass_hit = (rec_nxt_i >  R_PASS) || (tec_nxt_i >  T_PASS);
        off_hit  = (tec_nxt_i >  T_OFF);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_ACTIVE: begin
                if (off_hit)       st_d = FS_BUSOFF;
                else if (pass_hit) st_d = FS_PASSIVE;
            end
            FS_PASSIVE: begin
                if (off_hit)        st_d = FS_BUSOFF;
                else if (!pass_hit) st_d = FS_ACTIVE;
            end
            FS_BUSOFF: begin
                if (recover_i)      st_d = FS_ACTIVE;
            end
            default: st_d = FS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FS_ACTIVE;
            warn_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            warn_q <= warn_hit;
        end
    end

    always_comb begin
        state_o   = st_q;
        warn_o    = warn_q;
        busoff_o  = (st_q == FS_BUSOFF);
        passive_o = (st_q != FS_ACTIVE);
        clear_o   = (st_q == FS_BUSOFF) && recover_i;
    end

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
    import cft_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LEC_W     = 3,
    parameter int RX_BIG    = 8,
    parameter int TX_STEP   = 8,
    parameter int WARN_LIM  = 96,
    parameter int PASS_LIM  = 127,
    parameter int SNAP_ABV  = 128,
    parameter int SNAP_VAL  = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_err_i,
    input  logic             rx_severe_i,
    input  logic             rx_ok_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic [LEC_W-1:0] err_code_i,
    input  logic             recover_i,
    input  logic             sw_wr_i,
    input  logic [LEC_W-1:0] sw_lec_i,
    output logic [CNT_W-1:0] rec_o,
    output logic [CNT_W-1:0] tec_lo_o,
    output logic [LEC_W-1:0] lec_o,
    output logic             warn_o,
    output logic             passive_o,
    output logic             busoff_o,
    output logic [1:0]       fault_state_o
);
    localparam int TEC_W   = CNT_W + 1;
    localparam int OFF_LIM = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] rec_q, rec_nxt;
    logic [TEC_W-1:0] tec_q, tec_nxt;
    logic             frozen, clear;
    fault_st_e        state;

    cft_rx_counter #(
        .CNT_W(CNT_W), .SMALL_STEP(1), .BIG_STEP(RX_BIG),
        .SNAP_ABOVE(SNAP_ABV), .SNAP_TO(SNAP_VAL)
    ) rx_cnt_i (
        .clk(clk), .rst_n(rst_n), .hold_i(frozen), .clear_i(clear),
        .err_i(rx_err_i), .severe_i(rx_severe_i), .ok_i(rx_ok_i),
        .cnt_q(rec_q), .cnt_nxt(rec_nxt)
    );

    cft_tx_counter #(
        .TEC_W(TEC_W), .ERR_STEP(TX_STEP)
    ) tx_cnt_i (
        .clk(clk), .rst_n(rst_n), .hold_i(frozen), .clear_i(clear),
        .err_i(tx_err_i), .ok_i(tx_ok_i),
        .cnt_q(tec_q), .cnt_nxt(tec_nxt)
    );

    cft_state_fsm #(
        .CNT_W(CNT_W), .TEC_W(TEC_W), .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM), .OFF_LIM(OFF_LIM)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .recover_i(recover_i),
        .rec_nxt_i(rec_nxt), .tec_nxt_i(tec_nxt),
        .state_o(state), .warn_o(warn_o), .passive_o(passive_o),
        .busoff_o(frozen), .clear_o(clear)
    );

    cft_lec_reg #(
        .LEC_W(LEC_W), .SW_CODE({LEC_W{1'b1}})
    ) lec_i (
        .clk(clk), .rst_n(rst_n),
        .err_any_i(rx_err_i | tx_err_i), .ok_any_i(rx_ok_i | tx_ok_i),
        .code_i(err_code_i), .sw_wr_i(sw_wr_i), .sw_data_i(sw_lec_i),
        .lec_q(lec_o)
    );

    always_comb begin
        rec_o         = rec_q;
        tec_lo_o      = tec_q[CNT_W-1:0];
        busoff_o      = frozen;
        fault_state_o = state;
    end

endmodule

// File: rtl/cft_checker.sv
module cft_checker #(
    parameter int CNT_W = 8,
    parameter int LEC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_err_i,
    input logic             rx_severe_i,
    input logic             rx_ok_i,
    input logic             tx_err_i,
    input logic             tx_ok_i,
    input logic             recover_i,
    input logic [CNT_W-1:0] rec_o,
    input logic [CNT_W:0]   tec_full,
    input logic [LEC_W-1:0] lec_o,
    input logic             passive_o,
    input logic             busoff_o
);
    localparam logic [CNT_W-1:0] R_TOP  = CNT_W'((1 << CNT_W) - 9);
    localparam logic [CNT_W-1:0] R_SNAP = CNT_W'(128);
    localparam logic [CNT_W-1:0] R_SV   = CNT_W'(120);
    localparam logic [CNT_W-1:0] R_PAS  = CNT_W'(127);
    localparam logic [CNT_W:0]   T_PAS  = (CNT_W+1)'(127);
    localparam logic [CNT_W:0]   T_OFF  = (CNT_W+1)'((1 << CNT_W) - 1);

    // R2
    rx_big_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_o && rx_err_i && rx_severe_i && rec_o <= R_TOP)
        |=> rec_o == $past(rec_o) + CNT_W'(8));

    // R3
    rx_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_o && rx_ok_i && !rx_err_i && rec_o > R_SNAP) |=> rec_o == R_SV);

    // R4
    tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_o && tx_err_i && tec_full <= T_OFF)
        |=> tec_full == $past(tec_full) + (CNT_W+1)'(8));

    // R6
    passive_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        passive_o |-> (rec_o > R_PAS || tec_full > T_PAS));

    // R7
    busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busoff_o) |-> tec_full > T_OFF);

    // R8
    busoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_o && !recover_i) |=> ($stable(rec_o) && $stable(tec_full)));

    // R9
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_o && recover_i) |=> (rec_o == '0 && tec_full == '0 && !busoff_o));

    // R11
    lec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_err_i && !tx_err_i && (rx_ok_i || tx_ok_i)) |=> lec_o == '0);

    // R13 / R4
    tx_ok_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_o && tx_ok_i && !tx_err_i && tec_full == '0) |=> tec_full == '0);

endmodule

bind can_fault_tracker cft_checker #(.CNT_W(CNT_W), .LEC_W(LEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_err_i(rx_err_i), .rx_severe_i(rx_severe_i),
    .rx_ok_i(rx_ok_i), .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i),
    .recover_i(recover_i), .rec_o(rec_o), .tec_full(tec_q), .lec_o(lec_o),
    .passive_o(passive_o), .busoff_o(busoff_o)
);

// File: tb/can_fault_tracker_tb_top.sv
module can_fault_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_err_i = 0, rx_severe_i = 0, rx_ok_i = 0;
    logic       tx_err_i = 0, tx_ok_i = 0, recover_i = 0, sw_wr_i = 0;
    logic [2:0] err_code_i = 0, sw_lec_i = 0;
    logic [7:0] rec_o, tec_lo_o;
    logic [2:0] lec_o;
    logic       warn_o, passive_o, busoff_o;
    logic [1:0] fault_state_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int m_rec = 0, m_tec = 0, m_lec = 0, m_st = 0;

    always #10 clk = ~clk;

    can_fault_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .rx_err_i(rx_err_i), .rx_severe_i(rx_severe_i),
        .rx_ok_i(rx_ok_i), .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i),
        .err_code_i(err_code_i), .recover_i(recover_i), .sw_wr_i(sw_wr_i),
        .sw_lec_i(sw_lec_i), .rec_o(rec_o), .tec_lo_o(tec_lo_o), .lec_o(lec_o),
        .warn_o(warn_o), .passive_o(passive_o), .busoff_o(busoff_o),
        .fault_state_o(fault_state_o)
    );

    function automatic int rec_next(int r, bit e, bit sev, bit ok);
        if (e) return ((r + (sev ? 8 : 1)) > 255) ? 255 : r + (sev ? 8 : 1);
        if (ok) return (r > 128) ? 120 : ((r > 0) ? r - 1 : 0);
        return r;
    endfunction

    function automatic int tec_next(int t, bit e, bit ok);
        if (e) return t + 8;
        if (ok && t > 0) return t - 1;
        return t;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit rxe, bit sev, bit rxo, bit txe, bit txo, int code,
                        bit rcv, bit sw, int swd);
        @(negedge clk);
        rx_err_i = rxe; rx_severe_i = sev; rx_ok_i = rxo; tx_err_i = txe;
        tx_ok_i = txo; err_code_i = 3'(code); recover_i = rcv; sw_wr_i = sw;
        sw_lec_i = 3'(swd);
        if (rxe || txe) m_lec = code;
        else if (rxo || txo) m_lec = 0;
        else if (sw && swd == 7) m_lec = 7;
        if (m_st == 2) begin
            if (rcv) begin m_rec = 0; m_tec = 0; m_st = 0; end
        end else begin
            m_rec = rec_next(m_rec, rxe, sev, rxo);
            m_tec = tec_next(m_tec, txe, txo);
            m_st  = (m_tec > 255) ? 2 : ((m_rec > 127 || m_tec > 127) ? 1 : 0);
        end
        @(posedge clk);
        #2;
        chk("R2/R3 rec", rec_o, m_rec);
        chk("R4/R13 tec_lo", tec_lo_o, m_tec % 256);
        chk("R10 lec", lec_o, m_lec);
        chk("R5 warn", warn_o, (m_rec >= 96 || m_tec >= 96) ? 1 : 0);
        chk("R6 passive", passive_o, (m_st != 0) ? 1 : 0);
        chk("R7 busoff", busoff_o, (m_st == 2) ? 1 : 0);
        chk("R7 state", fault_state_o, m_st);
        rx_err_i = 0; rx_ok_i = 0; tx_err_i = 0; tx_ok_i = 0;
        recover_i = 0; sw_wr_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        #5;
        // R1 reset state
        chk("R1 rec", rec_o, 0);
        chk("R1 tec", tec_lo_o, 0);
        chk("R1 lec", lec_o, 0);
        chk("R1 flags", {warn_o, passive_o, busoff_o}, 0);
        chk("R1 state", fault_state_o, 0);

        step(1, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R2 small step", rec_o, 1);
        for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0, 2, 0, 0, 0);
        chk("R2 big step", rec_o, 129);
        chk("R6 passive at 129", passive_o, 1);
        step(0, 0, 1, 0, 0, 0, 0, 0, 0);
        chk("R3 snap to 120", rec_o, 120);
        chk("R11 lec cleared", lec_o, 0);
        step(1, 1, 0, 0, 0, 4, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0, 0);
        chk("R3 128 to 127", rec_o, 127);
        step(1, 0, 1, 0, 0, 6, 0, 0, 0);
        chk("R2 error wins over ok", rec_o, 128);
        step(0, 0, 0, 0, 0, 0, 0, 1, 5);
        chk("R12 write of 5 ignored", lec_o, 6);
        step(0, 0, 0, 0, 0, 0, 0, 1, 7);
        chk("R12 write of 7", lec_o, 7);
        step(1, 0, 0, 0, 0, 3, 0, 1, 7);
        chk("R12 hardware wins", lec_o, 3);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R9 recover ignored", rec_o, 129);
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, 5, 0, 0, 0);
        chk("R2 saturate", rec_o, 255);
        for (int i = 0; i < 32; i++) step(0, 0, 0, 1, 0, 3, 0, 0, 0);
        chk("R7 busoff entered", busoff_o, 1);
        chk("R13 low byte", tec_lo_o, 0);
        step(1, 1, 0, 1, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0, 0, 0, 0);
        chk("R8 rec frozen", rec_o, 255);
        chk("R8 tec frozen", tec_lo_o, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R9 recovered", {busoff_o, passive_o}, 0);
        chk("R9 rec cleared", rec_o, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 floor at 0", tec_lo_o, 0);

        for (int ph = 0; ph < 40; ph++) begin
            int perr = $urandom_range(5, 90);
            for (int k = 0; k < 100; k++) begin
                bit rxe = ($urandom_range(0, 99) < perr);
                bit txe = ($urandom_range(0, 99) < perr);
                bit rxo = ($urandom_range(0, 99) < 100 - perr);
                bit txo = ($urandom_range(0, 99) < 100 - perr);
                step(rxe, $urandom_range(0, 1) == 1, rxo, txe, txo,
                     $urandom_range(1, 6), $urandom_range(0, 9) == 0,
                     $urandom_range(0, 5) == 0, $urandom_range(6, 7));
            end
        end
        finish_run();
    end

endmodule